// File: doc/BRIEF.md
# Multi-Granule Stage-1 Address Walker

This block turns a 48-bit virtual address into a 48-bit physical address. It does this by following in-memory translation tables, one level at a time. While reset is held, the block latches a granule choice of 4KB, 16KB or 64KB. That choice fixes three things: the first level of the walk, the virtual-address bit field used at each level, and the levels at which a block mapping may end the walk.

A requester hands over a virtual address and a table base address. The block then issues one 64-bit descriptor read per level over a plain request/response memory port. It classifies each returned word as invalid, next-table pointer, block or page. It finishes by presenting either a physical address or a fault, together with the level at which the walk stopped. Only one walk is open at any time.

Top module: `xlat_walker`

## Requirements
- R1: While reset is low, the walker shows `req_ready`=1, `mem_rd_valid`=0 and `res_valid`=0. It latches `cfg_granule` (0=4KB, 1=16KB, 2=64KB, 3 behaves as 4KB). Later changes to `cfg_granule` have no effect until the next reset.
- R2: With the 4KB granule, the walk starts at level 0. The index fields are VA[47:39], VA[38:30], VA[29:21] and VA[20:12] for levels 0 to 3. Each read address is table base + index*8.
- R3: With the 16KB granule, the walk starts at level 0. Its index is VA[47] alone. Levels 1 to 3 use VA[46:36], VA[35:25] and VA[24:14]. Each read address is table base + index*8.
- R4: With the 64KB granule, the walk starts at level 1. Levels 1 to 3 use VA[47:42], VA[41:29] and VA[28:16]. Level 0 is never reported.
- R5: A descriptor with bit 0 = 0 ends the walk at its level with `res_fault`=1 and `res_pa`=0.
- R6: At levels 0 to 2, bits[1:0]=11 is a table pointer. The next table base is descriptor bits[47:G], with bits below G cleared. G is 12, 14 or 16 for the 4KB, 16KB or 64KB granule. Descriptor bits 63:48 are ignored.
- R7: At levels 0 to 2, bits[1:0]=01 at a level where blocks are allowed ends the walk without a fault. The allowed levels are: 4KB levels 1 and 2, 16KB level 2, 64KB levels 1 and 2. `res_pa` takes bits above that level's lowest index bit from the descriptor and the rest from the VA.
- R8: A block encoding (bits[1:0]=01) at a level where blocks are not allowed ends the walk with a fault at that level. Level 0 therefore never reports a successful result.
- R9: At level 3, bits[1:0]=11 is a page. `res_pa` = descriptor bits[47:G] joined with VA bits[G-1:0]. Bits[1:0]=01 at level 3 faults, exactly as an invalid descriptor does.
- R10: From the accepted request until the result handshake, `req_ready` stays 0. While `res_valid`=1 and `res_ready`=0, the result outputs hold steady.
- R11: While `mem_rd_valid`=1 and `mem_rd_ready`=0, the read request and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_granule | input | 2 | Granule code, latched during reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 48 | Virtual address to translate |
| req_base | input | 48 | Base address of the first-level table |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor word |
| res_valid | output | 1 | Walk result present |
| res_ready | input | 1 | Requester takes the result |
| res_pa | output | 48 | Physical address (0 on fault) |
| res_level | output | 2 | Level at which the walk ended |
| res_fault | output | 1 | Walk ended in a fault |

## Verification
The assertions assume a well-behaved environment:
- The memory returns exactly one response per accepted read, and only after that read is accepted.
- The requester holds its request fields steady until `req_ready` takes them.
- Each first-level table base is 8-byte aligned.

The bench keeps within these rules by design. Its memory model answers each handshake once, after 0 to 2 idle cycles. Its requester holds inputs until the acceptance it observed. Every table base it places is 64KB aligned. Absent entries read back as zero, so they exercise the invalid path.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned XW = 48;

  typedef enum logic [1:0] {GR_4K = 2'd0, GR_16K = 2'd1, GR_64K = 2'd2} gran_e;
  typedef enum logic [1:0] {DK_FAULT = 2'd0, DK_TABLE = 2'd1, DK_LEAF = 2'd2} dkind_e;

  function automatic gran_e gran_decode(input logic [1:0] code);
    case (code)
      2'd1:    return GR_16K;
      2'd2:    return GR_64K;
      default: return GR_4K;
    endcase
  endfunction

  function automatic logic [1:0] start_level(input gran_e g);
    return (g == GR_64K) ? 2'd1 : 2'd0;
  endfunction

  // lowest VA bit of the index field at a level (= log2 of region size)
  function automatic logic [5:0] lvl_shift(input gran_e g, input logic [1:0] l);
    case (g)
      GR_16K:
        case (l)
          2'd0: return 6'd47;
          2'd1: return 6'd36;
          2'd2: return 6'd25;
          default: return 6'd14;
        endcase
      GR_64K:
        case (l)
          2'd2: return 6'd29;
          2'd3: return 6'd16;
          default: return 6'd42;
        endcase
      default:
        case (l)
          2'd0: return 6'd39;
          2'd1: return 6'd30;
          2'd2: return 6'd21;
          default: return 6'd12;
        endcase
    endcase
  endfunction

  function automatic logic [5:0] idx_top(input gran_e g, input logic [1:0] l);
    if (l == start_level(g)) return 6'(XW - 1);
    return lvl_shift(g, l - 2'd1) - 6'd1;
  endfunction

  function automatic logic block_ok(input gran_e g, input logic [1:0] l);
    return (l == 2'd2) || ((l == 2'd1) && (g != GR_16K));
  endfunction

  function automatic logic [XW-1:0] hi_mask(input logic [5:0] sh);
    return {XW{1'b1}} << sh;
  endfunction

  function automatic logic [XW-1:0] splice(input logic [XW-1:0] hi,
                                           input logic [XW-1:0] lo,
                                           input logic [5:0] sh);
    return (hi & hi_mask(sh)) | (lo & ~hi_mask(sh));
  endfunction
endpackage

// File: rtl/xlat_index.sv
module xlat_index
  import xlat_pkg::*;
#(
  parameter int ADDR_W = XW,
  parameter int DESC_W = 64
) (
  input  gran_e             gran,
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] tbase,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int DSH = $clog2(DESC_W / 8);

  logic [5:0]        lo_b;
  logic [5:0]        hi_b;
  logic [ADDR_W-1:0] field_mask;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    lo_b       = lvl_shift(gran, level);
    hi_b       = idx_top(gran, level);
    field_mask = ~({ADDR_W{1'b1}} << (hi_b - lo_b + 6'd1));
    idx        = (va >> lo_b) & field_mask;
    rd_addr    = tbase + (idx << DSH);
  end
endmodule

// File: rtl/xlat_decode.sv
module xlat_decode
  import xlat_pkg::*;
#(
  parameter int ADDR_W = XW
) (
  input  gran_e             gran,
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output dkind_e            kind,
  output logic [ADDR_W-1:0] leaf_pa,
  output logic [ADDR_W-1:0] next_base
);
  logic [5:0] gsh;
  logic [5:0] rsh;

  always_comb begin
    kind      = DK_FAULT;
    leaf_pa   = '0;
    next_base = '0;
    gsh       = lvl_shift(gran, 2'd3);
    rsh       = lvl_shift(gran, level);
    if (desc[0]) begin
      if (level == 2'd3) begin
        if (desc[1]) begin
          kind    = DK_LEAF;
          leaf_pa = splice(desc, va, gsh);
        end
      end else if (desc[1]) begin
        kind      = DK_TABLE;
        next_base = desc & hi_mask(gsh);
      end else if (block_ok(gran, level)) begin
        kind    = DK_LEAF;
        leaf_pa = splice(desc, va, rsh);
      end
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int DESC_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_granule,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [XW-1:0]     req_va,
  input  logic [XW-1:0]     req_base,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [XW-1:0]     mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [XW-1:0]     res_pa,
  output logic [1:0]        res_level,
  output logic              res_fault
);
  localparam int ADDR_W = XW;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WAIT, S_DONE} wstate_e;

  wstate_e           state_q;
  gran_e             gran_q;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] tbase_q;
  logic [1:0]        lvl_q;
  logic [ADDR_W-1:0] pa_q;
  logic              fault_q;

  dkind_e            dec_kind;
  logic [ADDR_W-1:0] dec_pa;
  logic [ADDR_W-1:0] dec_next;
  logic              unused_desc_hi;

  // named events for the checks
  logic walk_start;
  logic step_table;
  logic walk_end;
  logic res_taken;

  assign unused_desc_hi = ^mem_rsp_data[DESC_W-1:ADDR_W];

  assign req_ready    = (state_q == S_IDLE);
  assign mem_rd_valid = (state_q == S_READ);
  assign res_valid    = (state_q == S_DONE);
  assign res_pa       = pa_q;
  assign res_level    = lvl_q;
  assign res_fault    = fault_q;

  assign walk_start = req_valid && req_ready;
  assign step_table = (state_q == S_WAIT) && mem_rsp_valid && (dec_kind == DK_TABLE);
  assign walk_end   = (state_q == S_WAIT) && mem_rsp_valid && (dec_kind != DK_TABLE);
  assign res_taken  = res_valid && res_ready;

  xlat_index #(.ADDR_W(ADDR_W), .DESC_W(DESC_W)) u_index (
    .gran    (gran_q),
    .level   (lvl_q),
    .va      (va_q),
    .tbase   (tbase_q),
    .rd_addr (mem_rd_addr)
  );

  xlat_decode #(.ADDR_W(ADDR_W)) u_decode (
    .gran      (gran_q),
    .level     (lvl_q),
    .desc      (mem_rsp_data[ADDR_W-1:0]),
    .va        (va_q),
    .kind      (dec_kind),
    .leaf_pa   (dec_pa),
    .next_base (dec_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) gran_q <= gran_decode(cfg_granule);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      tbase_q <= '0;
      lvl_q   <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (walk_start) begin
          va_q    <= req_va;
          tbase_q <= req_base;
          lvl_q   <= start_level(gran_q);
          pa_q    <= '0;
          fault_q <= 1'b0;
          state_q <= S_READ;
        end
        S_READ: if (mem_rd_ready) state_q <= S_WAIT;
        S_WAIT: if (step_table) begin
          tbase_q <= dec_next;
          lvl_q   <= lvl_q + 2'd1;
          state_q <= S_READ;
        end else if (walk_end) begin
          fault_q <= (dec_kind == DK_FAULT);
          pa_q    <= (dec_kind == DK_FAULT) ? '0 : dec_pa;
          state_q <= S_DONE;
        end
        default: if (res_taken) state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !req_ready);
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_level) && $stable(res_fault));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  // R6
  table_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_table |=> mem_rd_valid);
  // R5
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_pa == '0);
  // R8
  no_l0_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_level != 2'd0);
  // R4
  start_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_rd_valid) && gran_q == GR_64K |-> lvl_q != 2'd0);
  // R10
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_rd_valid, res_valid}));
endmodule

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  cfg_granule = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [47:0] req_va = 0;
  logic [47:0] req_base = 0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 0;
  logic [47:0] mem_rd_addr;
  logic        mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = 0;
  logic        res_valid;
  logic        res_ready = 0;
  logic [47:0] res_pa;
  logic [1:0]  res_level;
  logic        res_fault;

  always #2.5 clk = ~clk;

  xlat_walker u_dut (.*);

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [63:0] tbl [logic [47:0]];
  logic [47:0] exp_rd[$];
  logic [47:0] exp_pa;
  int          exp_lvl;
  bit          exp_fault;
  string       exp_tag;
  string       rd_tag;

  bit busy = 0, accepted = 0, done = 0, run_mon = 0;
  bit rsp_pend = 0, rd_wait_prev = 0, res_wait_prev = 0;
  int rsp_cnt = 0;
  logic [63:0] rsp_data;
  logic [47:0] prev_addr, prev_pa;
  logic [1:0]  prev_lvl;
  logic        prev_fault;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_sh(int g, int l);
    case (g)
      1: return 14 + 11 * (3 - l);
      2: return 16 + 13 * (3 - l);
      default: return 12 + 9 * (3 - l);
    endcase
  endfunction

  function automatic int ref_first(int g);
    return (g == 2) ? 1 : 0;
  endfunction

  function automatic logic [47:0] ref_idx(int g, int l, logic [47:0] va);
    int s = ref_sh(g, l);
    int t = (l == ref_first(g)) ? 47 : ref_sh(g, l - 1) - 1;
    logic [47:0] one = 48'd1;
    return (va >> s) & ((one << (t - s + 1)) - 48'd1);
  endfunction

  function automatic logic [47:0] ref_keep(logic [63:0] d, logic [47:0] va, int s);
    logic [47:0] h = d[47:0];
    return ((h >> s) << s) | (va - ((va >> s) << s));
  endfunction

  task automatic ref_walk(input int g, input logic [47:0] va, input logic [47:0] base);
    logic [47:0] b = base;
    logic [47:0] a;
    logic [63:0] d;
    bit fin = 0;
    exp_rd.delete();
    exp_fault = 0;
    exp_pa = 0;
    for (int l = ref_first(g); l <= 3 && !fin; l++) begin
      a = b + ref_idx(g, l, va) * 8;
      exp_rd.push_back(a);
      d = tbl.exists(a) ? tbl[a] : 64'h0;
      exp_lvl = l;
      if (!d[0]) begin exp_fault = 1; fin = 1; end
      else if (l == 3) begin
        if (d[1]) exp_pa = ref_keep(d, va, ref_sh(g, 3)); else exp_fault = 1;
        fin = 1;
      end else if (d[1]) b = (d[47:0] >> ref_sh(g, 3)) << ref_sh(g, 3);
      else begin
        if (l == 2 || (l == 1 && g != 1)) exp_pa = ref_keep(d, va, ref_sh(g, l));
        else exp_fault = 1;
        fin = 1;
      end
    end
  endtask

  // memory model, requester monitor and per-clock comparison
  always @(negedge clk) begin
    if (rst_n && run_mon) begin
      chk(req_ready == !busy, "R10 req_ready vs walk open", 64'(req_ready), 64'(!busy));
      if (rd_wait_prev)
        chk(mem_rd_valid && mem_rd_addr == prev_addr, "R11 read held", 64'(mem_rd_addr), 64'(prev_addr));
      if (res_wait_prev)
        chk(res_valid && res_pa == prev_pa && res_level == prev_lvl && res_fault == prev_fault,
            "R10 result held", 64'(res_pa), 64'(prev_pa));
      mem_rsp_valid = 0;
      if (rsp_pend) begin
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = rsp_data;
          rsp_pend = 0;
        end else rsp_cnt--;
      end
      mem_rd_ready = ($urandom % 3) != 0;
      if (mem_rd_valid && mem_rd_ready) begin
        if (exp_rd.size() == 0) chk(0, {rd_tag, " unexpected read"}, 64'(mem_rd_addr), 64'h0);
        else chk(mem_rd_addr == exp_rd[0], {rd_tag, " read address"}, 64'(mem_rd_addr), 64'(exp_rd[0]));
        if (exp_rd.size() != 0) void'(exp_rd.pop_front());
        rsp_pend = 1;
        rsp_cnt = $urandom % 3;
        rsp_data = tbl.exists(mem_rd_addr) ? tbl[mem_rd_addr] : 64'h0;
      end
      rd_wait_prev = mem_rd_valid && !mem_rd_ready;
      prev_addr = mem_rd_addr;
      res_ready = ($urandom % 2) != 0;
      if (res_valid && res_ready) begin
        chk(res_fault == exp_fault, {exp_tag, " fault"}, 64'(res_fault), 64'(exp_fault));
        chk(res_level == 2'(exp_lvl), {exp_tag, " level"}, 64'(res_level), 64'(exp_lvl));
        chk(res_pa == exp_pa, {exp_tag, " pa"}, 64'(res_pa), 64'(exp_pa));
        chk(exp_rd.size() == 0, {exp_tag, " read count"}, 64'(exp_rd.size()), 64'h0);
        busy = 0;
        done = 1;
      end
      res_wait_prev = res_valid && !res_ready;
      prev_pa = res_pa; prev_lvl = res_level; prev_fault = res_fault;
      if (req_valid && req_ready) begin
        busy = 1;
        accepted = 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic build_chain(input int g, input logic [47:0] va, input logic [47:0] base,
                             input int stop, input logic [63:0] fin);
    logic [47:0] b = base;
    logic [47:0] nb;
    tbl.delete();
    for (int l = ref_first(g); l < stop; l++) begin
      nb = 48'h20_0000_0000 + 48'(l + 1) * 48'h1000_0000 + 48'h0123_0000;
      tbl[b + ref_idx(g, l, va) * 8] = 64'hA5A0_0000_0000_0000 | 64'(nb) | 64'h0F3;
      b = nb;
    end
    tbl[b + ref_idx(g, stop, va) * 8] = fin;
  endtask

  task automatic walk(input int g, input int stop, input logic [63:0] fin, input string tag,
                      input logic [47:0] va);
    logic [47:0] base = 48'h7_0000_0000;
    build_chain(g, va, base, stop, fin);
    ref_walk(g, va, base);
    exp_tag = tag;
    @(posedge clk); #1;
    accepted = 0; done = 0;
    req_valid = 1; req_va = va; req_base = base;
    do begin @(posedge clk); #1; end while (!accepted);
    req_valid = 0;
    do begin @(posedge clk); #1; end while (!done);
  endtask

  function automatic logic [47:0] rva();
    return {$urandom, $urandom};
  endfunction

  task automatic phase(input int code);
    int g = (code == 3) ? 0 : code;
    run_mon = 0;
    busy = 0; rsp_pend = 0; rd_wait_prev = 0; res_wait_prev = 0;
    @(posedge clk); #1;
    rst_n = 0; cfg_granule = 2'(code);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cfg_granule = 2'(code + 1);   // must be ignored until the next reset (R1)
    @(negedge clk);
    chk(req_ready && !mem_rd_valid && !res_valid, "R1 reset state",
        {61'd0, req_ready, mem_rd_valid, res_valid}, 64'h4);
    run_mon = 1;
    rd_tag = (g == 0) ? "R2" : (g == 1) ? "R3" : "R4";
    for (int k = 0; k < 4; k++)
      walk(g, 3, 64'hFFFF_9876_5432_1FF3 ^ (64'(k) << 20), "R6 R9 R1 page", rva());
    walk(g, 2, 64'h0000_8765_4321_0FF1, "R7 block level2", rva());
    if (g == 1) walk(g, 1, 64'h0000_ABCD_4000_0001, "R8 block level1", rva());
    else        walk(g, 1, 64'h0000_ABCD_4000_0001, "R7 block level1", rva());
    if (g != 2) walk(g, 0, 64'h0000_8000_0000_0001, "R8 block level0", rva());
    walk(g, ref_first(g), 64'hFFFF_FFFF_FFFF_FFFE, "R5 invalid first", rva());
    walk(g, 2, 64'h0000_1234_5678_0002, "R5 invalid level2", rva());
    walk(g, 3, 64'h0000_1234_5678_9001, "R9 level3 reserved", rva());
    walk(g, 3, 64'h0000_0000_0000_0000, "R5 empty level3", rva());
  endtask

  initial begin
    phase(0);
    phase(1);
    phase(2);
    phase(3);
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule